// File: doc/BRIEF.md
# Write Status Polling Read Path

This block sits between the storage array of a byte-wide nonvolatile memory model and its read data bus. It decides what a read returns. When no write is being programmed, a read returns the array word at the addressed location. While the write controller reports that a program cycle is running, a read returns a status word instead. That status word carries two separate end-of-write indicators. The top bit is the inverse of the top bit of the last byte written. The next bit alternates from one read to the next. The six low bits echo the last written byte.

The strobes are sampled on the system clock. A read is decoded when chip select and output enable are both low and write enable is high. The selected word is registered and presented one clock later, together with a data-valid flag. The flag stands in for the output drivers being enabled, and the data is forced to zero whenever it is low. A read counts as finished in the first sampled cycle where the read condition no longer holds, whether chip select or output enable rose. Only a finished read advances the alternating bit. Polling may begin in any cycle of the program cycle, including the cycle in which the busy flag rises.

Top module: `wstat_read_path`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `rd_valid` is 0 and `rd_data` is 0.
- R2: A read is a sampled cycle with `cs_n`=0, `oe_n`=0 and `we_n`=1. One clock after a read cycle, `rd_valid` is 1. One clock after any other cycle, including `we_n`=0 with `cs_n` and `oe_n` low, `rd_valid` is 0 and `rd_data` is all zeros.
- R3: With `wr_busy`=0 at the read cycle, `rd_data` one clock later equals `arr_data` as sampled in that read cycle.
- R4: With `wr_busy`=1 at the read cycle, `rd_data[7]` one clock later is the inverse of `wr_last[7]` as sampled in that cycle.
- R5: With `wr_busy`=1 at the read cycle, `rd_data[5:0]` one clock later equals `wr_last[5:0]` as sampled in that cycle.
- R6: In the first read of a program cycle, `rd_data[6]` is the inverse of the `wr_last[6]` value sampled in the cycle where `wr_busy` rose.
- R7: While `wr_busy`=1, each finished read inverts the `rd_data[6]` value that the next read returns. All cycles of a single multi-cycle read return the same bit 6. A finished read is a cycle where the previous sampled cycle was a read and the current one is not.
- R8: After `wr_busy` falls, reads return `arr_data` on all eight bits, and finished reads do not move the alternating bit.
- R9: A read already in progress when `wr_busy` rises switches to the status word in that same sampled cycle. Its bit 6 is the R6 seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wr_busy | input | 1 | Program cycle in progress, from the write controller |
| wr_last | input | 8 | Last byte written, from the write controller |
| arr_data | input | 8 | Array word at the current address |
| rd_data | output | 8 | Read data, zero when not valid |
| rd_valid | output | 1 | Read data valid (output drivers enabled) |

## Verification
Each result is due exactly one clock after the rising edge that samples the strobes and data. A change in the alternating bit becomes visible only on a read that follows the finishing cycle of an earlier read. The bench's reference model is evaluated on the same rising edge as the design, and it compares the registered outputs on the following falling edge. Every expected value is therefore taken from the inputs held over exactly one edge. The stimulus starts a read in the very cycle the busy flag rises. It also ends reads with chip select on some and with output enable on others, and it holds reads for several cycles to show that bit 6 stays steady within a read.

// File: rtl/wstat_pkg.sv
package wstat_pkg;
  localparam int WORD_W   = 8;
  localparam int POLL_POS = WORD_W - 1;
  localparam int TOG_POS  = WORD_W - 2;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_ARRAY  = 2'd1,
    SRC_STATUS = 2'd2
  } src_e;

  // strobe combination that makes a read cycle
  function automatic logic read_strobe(logic cs_n, logic oe_n, logic we_n);
    return !cs_n && !oe_n && we_n;
  endfunction

  // status word shown during a program cycle
  function automatic word_t status_word(word_t last, logic tog);
    word_t w;
    w           = last;
    w[POLL_POS] = ~last[POLL_POS];
    w[TOG_POS]  = tog;
    return w;
  endfunction

  function automatic logic next_toggle(logic cur, logic advance);
    return advance ? ~cur : cur;
  endfunction

  function automatic src_e pick_source(logic rd, logic busy);
    if (!rd)  return SRC_NONE;
    if (busy) return SRC_STATUS;
    return SRC_ARRAY;
  endfunction
endpackage

// File: rtl/wstat_strobe_decode.sv
module wstat_strobe_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic busy,
  output logic read_now,
  output logic read_end,
  output logic busy_rise
);
  import wstat_pkg::*;

  logic read_q;
  logic busy_q;

  assign read_now  = read_strobe(cs_n, oe_n, we_n);
  assign read_end  = read_q && !read_now;
  assign busy_rise = busy && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      read_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      read_q <= read_now;
      busy_q <= busy;
    end
  end
endmodule

// File: rtl/wstat_toggle_track.sv
module wstat_toggle_track (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic busy_rise,
  input  logic read_end,
  input  logic seed_bit,
  output logic tog_eff,
  output logic tog_q
);
  import wstat_pkg::*;

  logic advance;

  // a fresh program cycle reseeds from the inverse of the written bit
  assign tog_eff = busy_rise ? ~seed_bit : tog_q;
  assign advance = busy && read_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= next_toggle(tog_eff, advance);
  end
endmodule

// File: rtl/wstat_data_sel.sv
module wstat_data_sel (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         read_now,
  input  logic                         busy,
  input  logic                         tog_eff,
  input  logic [wstat_pkg::WORD_W-1:0] last_byte,
  input  logic [wstat_pkg::WORD_W-1:0] array_data,
  output logic [wstat_pkg::WORD_W-1:0] rd_data,
  output logic                         rd_valid
);
  import wstat_pkg::*;

  src_e  src;
  word_t next_word;

  assign src = pick_source(read_now, busy);

  always_comb begin
    unique case (src)
      SRC_ARRAY:  next_word = array_data;
      SRC_STATUS: next_word = status_word(last_byte, tog_eff);
      default:    next_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_data  <= next_word;
      rd_valid <= (src != SRC_NONE);
    end
  end
endmodule

// File: rtl/wstat_read_path.sv
module wstat_read_path (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       oe_n,
  input  logic       we_n,
  input  logic       wr_busy,
  input  logic [7:0] wr_last,
  input  logic [7:0] arr_data,
  output logic [7:0] rd_data,
  output logic       rd_valid
);
  import wstat_pkg::*;

  // named internal events, observed by the bound checker
  logic read_now;
  logic read_end;
  logic busy_rise;
  logic tog_eff;
  logic tog_q;

  wstat_strobe_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .busy      (wr_busy),
    .read_now  (read_now),
    .read_end  (read_end),
    .busy_rise (busy_rise)
  );

  wstat_toggle_track u_tog (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (wr_busy),
    .busy_rise (busy_rise),
    .read_end  (read_end),
    .seed_bit  (wr_last[TOG_POS]),
    .tog_eff   (tog_eff),
    .tog_q     (tog_q)
  );

  wstat_data_sel u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .read_now   (read_now),
    .busy       (wr_busy),
    .tog_eff    (tog_eff),
    .last_byte  (wr_last),
    .array_data (arr_data),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid)
  );
endmodule

// File: rtl/wstat_read_path_chk.sv
module wstat_read_path_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       oe_n,
  input logic       we_n,
  input logic       wr_busy,
  input logic [7:0] wr_last,
  input logic [7:0] arr_data,
  input logic [7:0] rd_data,
  input logic       rd_valid,
  input logic       read_end,
  input logic       busy_rise,
  input logic       tog_q
);
  logic strobe_rd;
  assign strobe_rd = !cs_n && !oe_n && we_n;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!rd_valid && rd_data == 8'h00));

  // R2
  read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_rd |=> rd_valid);

  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_rd |=> (!rd_valid && rd_data == 8'h00));

  // R3
  array_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_rd && !wr_busy) |=> rd_data == $past(arr_data));

  // R4
  poll_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_rd && wr_busy) |=> rd_data[7] == ~$past(wr_last[7]));

  // R5
  low_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_rd && wr_busy) |=> rd_data[5:0] == $past(wr_last[5:0]));

  // R6
  seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_rise && !read_end) |=> tog_q == ~$past(wr_last[6]));

  // R7
  toggle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_busy && read_end && !busy_rise) |=> tog_q != $past(tog_q));

  // R8
  toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_busy |=> $stable(tog_q));
endmodule

bind wstat_read_path wstat_read_path_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .oe_n      (oe_n),
  .we_n      (we_n),
  .wr_busy   (wr_busy),
  .wr_last   (wr_last),
  .arr_data  (arr_data),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .read_end  (read_end),
  .busy_rise (busy_rise),
  .tog_q     (tog_q)
);

// File: tb/wstat_read_path_tb_top.sv
module wstat_read_path_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       oe_n = 1'b1;
  logic       we_n = 1'b1;
  logic       wr_busy = 1'b0;
  logic [7:0] wr_last = 8'h00;
  logic [7:0] arr_data = 8'h00;
  logic [7:0] rd_data;
  logic       rd_valid;

  int vectors = 0;
  int misses = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wstat_read_path dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .wr_busy(wr_busy), .wr_last(wr_last), .arr_data(arr_data),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // behavioural reference: kind 0 = quiet, 1 = array word, 2 = status word
  int         m_kind = 0;
  logic [7:0] m_word = 8'h00;
  int         m_alt = 0;
  bit         m_prev_rd = 1'b0;
  bit         m_prev_busy = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    bit rd;
    int alt_now;
    if (!rst_n) begin
      m_kind <= 0; m_word <= 8'h00; m_alt <= 0;
      m_prev_rd <= 1'b0; m_prev_busy <= 1'b0;
    end else begin
      rd = (cs_n == 1'b0) && (oe_n == 1'b0) && (we_n == 1'b1);
      alt_now = (wr_busy && !m_prev_busy) ? (wr_last[6] ? 0 : 1) : m_alt;
      if (!rd) begin
        m_kind <= 0; m_word <= 8'h00;
      end else if (wr_busy) begin
        m_kind <= 2;
        m_word <= {~wr_last[7], alt_now[0], wr_last[5:0]};
      end else begin
        m_kind <= 1; m_word <= arr_data;
      end
      if (wr_busy && m_prev_rd && !rd) m_alt <= 1 - alt_now;
      else                             m_alt <= alt_now;
      m_prev_rd   <= rd;
      m_prev_busy <= wr_busy;
    end
  end

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (m_kind == 0) begin
        check("R2 valid low", rd_valid, 0);
        check("R2 quiet data", rd_data, 0);
      end else begin
        check("R2 valid high", rd_valid, 1);
        if (m_kind == 1) check("R3/R8 array word", rd_data, m_word);
        else begin
          check("R4 poll bit", rd_data[7], m_word[7]);
          check("R5 low bits", rd_data[5:0], m_word[5:0]);
          check("R6/R7 toggle bit", rd_data[6], m_word[6]);
        end
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // read lasting len cycles, ended by output enable or by chip select
  task automatic rd(int len, bit end_by_cs, logic [7:0] word);
    @(negedge clk);
    arr_data = word; cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    for (int i = 1; i < len; i++) @(negedge clk);
    @(negedge clk);
    if (end_by_cs) cs_n = 1'b1; else oe_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1; oe_n = 1'b1;
  endtask

  initial begin
    idle(2);
    // R1
    check("R1 reset valid", rd_valid, 0);
    check("R1 reset data", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post-reset valid", rd_valid, 0);

    // R2, R3: reads of the array with no program cycle
    rd(1, 1'b0, 8'h3C);
    rd(3, 1'b1, 8'hC3);
    idle(2);
    // R2: write enable low is not a read
    @(negedge clk); cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
    idle(2);
    cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    idle(2);

    // R9: read starts in the cycle busy rises
    @(negedge clk);
    wr_last = 8'hA5; wr_busy = 1'b1; cs_n = 1'b0; oe_n = 1'b0; arr_data = 8'h11;
    idle(3);
    oe_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
    // R6, R7: alternating reads, mixed endings and lengths
    rd(1, 1'b1, 8'h22);
    rd(2, 1'b0, 8'h33);
    rd(4, 1'b1, 8'h44);
    wr_last = 8'hA7; // page write continues with a new last byte, R4, R5
    rd(1, 1'b0, 8'h55);
    // R8: program cycle ends, true data, alternation frozen
    @(negedge clk); wr_busy = 1'b0;
    rd(1, 1'b0, 8'hF0);
    rd(2, 1'b1, 8'h0F);

    // R6: second program cycle with bit 6 set, R7 steps
    @(negedge clk); wr_last = 8'h5A; wr_busy = 1'b1;
    idle(2);
    rd(1, 1'b0, 8'h99);
    rd(1, 1'b1, 8'h98);
    rd(2, 1'b0, 8'h97);
    @(negedge clk); wr_busy = 1'b0;
    rd(1, 1'b1, 8'h81);
    idle(3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      misses++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule